// File: doc/BRIEF.md
# Receive Command Detector and Cell Descrambler

This block sits on the receive side of a nibble-oriented cell link, after the symbol decoder. Each cycle it may accept one decoded nibble that carries a flag saying whether the nibble is an escape or data. Escapes introduce two-nibble commands. One command is a timing marker. Two others start a cell: a plain start and a start that also locks the scrambler. The block keeps a 10-bit descrambling generator in step with the far-end scrambler, strips the mask from the data nibbles, pairs the nibbles into bytes and delivers one fixed-length cell of 53 bytes after each start-of-cell. The cell comes out with start and end markers.

Timing markers produce a one-cycle pulse and may sit anywhere in the stream, including inside a cell. An escape that is followed by an unknown value raises a one-cycle error pulse. A new start-of-cell always wins over a cell that is still in progress.

Top module: `rxc_rx_top`

## Requirements
- R1: An escape followed by data nibble 0x8 is a timing marker: `tmark_pulse` is high for exactly the one cycle after the 0x8 nibble is accepted, and no cell byte results.
- R2: An escape followed by another escape, or an escape followed by data nibble 0x4, starts a cell: the next 106 data nibbles produce exactly 53 output bytes, then the block stops delivering.
- R3: Each output byte holds the first received data nibble in bits 7:4 and the second in bits 3:0.
- R4: Each byte appears with `cell_valid` high for one cycle, in the cycle after its second nibble is accepted. `cell_sop` is set only on byte 0 of a cell and `cell_eop` only on byte 52.
- R5: The generator follows x^10 + x^7 + 1. It shifts left one bit per step, and the new bit 0 is bit 9 XOR bit 6. It takes four steps on every accepted nibble, command nibbles and nibbles outside a cell included. A data nibble is XORed with generator bits 9:6, bit 9 onto nibble bit 3.
- R6: An escape accepted right after another escape loads the generator with 0x3FF instead of stepping it, so the first data nibble after an escape pair is XORed with 0xF.
- R7: In the stream escape, escape, escape, 0x8, the first two escapes start a locked cell and the last two nibbles form a timing marker. The reload happens on both the second and the third escape, and the 0x8 steps the generator.
- R8: A timing marker inside a cell pulses `tmark_pulse` and leaves the byte count and the byte contents of that cell unchanged.
- R9: An escape followed by a data nibble other than 0x4 or 0x8 pulses `cmd_err` for one cycle and starts no cell.
- R10: A start-of-cell that arrives during a cell abandons the partial cell without `cell_eop`, and a full 53-byte cell with a new `cell_sop` follows.
- R11: Data nibbles accepted outside a cell produce no output bytes.
- R12: While reset is held and after it is released, `cell_valid`, `cell_sop`, `cell_eop`, `tmark_pulse` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_valid | input | 1 | A nibble is presented this cycle |
| nib_is_esc | input | 1 | The presented nibble is an escape |
| nib_data | input | 4 | Nibble value when it is not an escape |
| cell_byte | output | 8 | Descrambled cell byte |
| cell_valid | output | 1 | `cell_byte` is valid this cycle |
| cell_sop | output | 1 | Byte 0 of a cell |
| cell_eop | output | 1 | Byte 52 of a cell |
| tmark_pulse | output | 1 | Timing marker received |
| cmd_err | output | 1 | Escape followed by an unknown value |

## Verification
The hardest case to reach from the ports is the escape run in which a lock start-of-cell and a timing marker share an escape boundary. There the generator reloads twice, then steps once on a command nibble before the first data nibble arrives. The bench drives that exact sequence and follows it with a full cell. Its payload is masked by a bench-side generator model, so every byte matches only if the reload and step points agree. Stray data outside a cell, placed before a plain start-of-cell, also shows through the payload whether the generator kept stepping while no cell was open.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  // Decoded command events for one accepted nibble
  typedef struct packed {
    logic soc_lock;   // escape, escape
    logic soc_plain;  // escape, start code
    logic tmark;      // escape, marker code
    logic bad;        // escape, unknown value
    logic data;       // ordinary data nibble
  } rxc_evt_t;
endpackage

// File: rtl/rxc_cmd_decoder.sv
module rxc_cmd_decoder
  import rxc_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int CODE_SOC  = 4,
  parameter int CODE_TM   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_valid,
  input  logic             nib_is_esc,
  input  logic [NIB_W-1:0] nib_data,
  output rxc_evt_t         evt,
  output logic             tmark_pulse,
  output logic             cmd_err
);
  localparam logic [NIB_W-1:0] SOC_V = NIB_W'(CODE_SOC);
  localparam logic [NIB_W-1:0] TM_V  = NIB_W'(CODE_TM);

  logic pend_q, pend_d;
  logic tm_q, tm_d;
  logic err_q, err_d;

  always_comb begin
    evt    = '0;
    pend_d = pend_q;
    if (nib_valid) begin
      if (pend_q) begin
        pend_d = 1'b0;
        if (nib_is_esc)            evt.soc_lock  = 1'b1;
        else if (nib_data == SOC_V) evt.soc_plain = 1'b1;
        else if (nib_data == TM_V)  evt.tmark     = 1'b1;
        else                        evt.bad       = 1'b1;
      end else if (nib_is_esc) begin
        pend_d = 1'b1;
      end else begin
        evt.data = 1'b1;
      end
    end
    tm_d  = evt.tmark;
    err_d = evt.bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tm_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      tm_q   <= tm_d;
      err_q  <= err_d;
    end
  end

  assign tmark_pulse = tm_q;
  assign cmd_err     = err_q;
endmodule

// File: rtl/rxc_descrambler.sv
module rxc_descrambler #(
  parameter int NIB_W   = 4,
  parameter int GEN_W   = 10,
  parameter int GEN_TAP = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_valid,
  input  logic             nib_is_esc,
  input  logic [NIB_W-1:0] nib_data,
  output logic [NIB_W-1:0] nib_plain
);
  localparam int TAP_IDX = GEN_TAP - 1;

  logic [GEN_W-1:0] gen_q, gen_d, gen_adv;
  logic             last_esc_q, last_esc_d;

  // NIB_W single-bit steps of the generator
  always_comb begin
    gen_adv = gen_q;
    for (int s = 0; s < NIB_W; s++) begin
      gen_adv = {gen_adv[GEN_W-2:0], gen_adv[GEN_W-1] ^ gen_adv[TAP_IDX]};
    end
  end

  always_comb begin
    gen_d      = gen_q;
    last_esc_d = last_esc_q;
    if (nib_valid) begin
      last_esc_d = nib_is_esc;
      if (nib_is_esc && last_esc_q) gen_d = '1;
      else                          gen_d = gen_adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q      <= '1;
      last_esc_q <= 1'b0;
    end else begin
      gen_q      <= gen_d;
      last_esc_q <= last_esc_d;
    end
  end

  assign nib_plain = nib_data ^ gen_q[GEN_W-1 -: NIB_W];
endmodule

// File: rtl/rxc_cell_framer.sv
module rxc_cell_framer
  import rxc_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int CELL_BYTES = 53
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rxc_evt_t           evt,
  input  logic [NIB_W-1:0]   nib_plain,
  output logic [2*NIB_W-1:0] cell_byte,
  output logic               cell_valid,
  output logic               cell_sop,
  output logic               cell_eop
);
  localparam int BYTE_W = 2 * NIB_W;
  localparam int CNT_W  = $clog2(CELL_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_BYTES - 1);

  logic              in_cell_q, in_cell_d;
  logic              have_hi_q, have_hi_d;
  logic [NIB_W-1:0]  hi_q, hi_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d, sop_q, sop_d, eop_q, eop_d;
  logic              start;

  assign start = evt.soc_lock | evt.soc_plain;

  always_comb begin
    in_cell_d = in_cell_q;
    have_hi_d = have_hi_q;
    hi_d      = hi_q;
    cnt_d     = cnt_q;
    byte_d    = byte_q;
    vld_d     = 1'b0;
    sop_d     = 1'b0;
    eop_d     = 1'b0;
    if (start) begin
      in_cell_d = 1'b1;
      have_hi_d = 1'b0;
      cnt_d     = '0;
    end else if (evt.data && in_cell_q) begin
      if (!have_hi_q) begin
        hi_d      = nib_plain;
        have_hi_d = 1'b1;
      end else begin
        have_hi_d = 1'b0;
        byte_d    = {hi_q, nib_plain};
        vld_d     = 1'b1;
        sop_d     = (cnt_q == '0);
        eop_d     = (cnt_q == LAST);
        if (cnt_q == LAST) begin
          in_cell_d = 1'b0;
          cnt_d     = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cell_q <= 1'b0;
      have_hi_q <= 1'b0;
      hi_q      <= '0;
      cnt_q     <= '0;
      byte_q    <= '0;
      vld_q     <= 1'b0;
      sop_q     <= 1'b0;
      eop_q     <= 1'b0;
    end else begin
      in_cell_q <= in_cell_d;
      have_hi_q <= have_hi_d;
      hi_q      <= hi_d;
      cnt_q     <= cnt_d;
      byte_q    <= byte_d;
      vld_q     <= vld_d;
      sop_q     <= sop_d;
      eop_q     <= eop_d;
    end
  end

  assign cell_byte  = byte_q;
  assign cell_valid = vld_q;
  assign cell_sop   = sop_q;
  assign cell_eop   = eop_q;
endmodule

// File: rtl/rxc_rx_top.sv
module rxc_rx_top
  import rxc_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int GEN_W      = 10,
  parameter int GEN_TAP    = 7,
  parameter int CELL_BYTES = 53,
  parameter int CODE_SOC   = 4,
  parameter int CODE_TM    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nib_valid,
  input  logic               nib_is_esc,
  input  logic [NIB_W-1:0]   nib_data,
  output logic [2*NIB_W-1:0] cell_byte,
  output logic               cell_valid,
  output logic               cell_sop,
  output logic               cell_eop,
  output logic               tmark_pulse,
  output logic               cmd_err
);
  rxc_evt_t         evt;
  logic [NIB_W-1:0] nib_plain;

  rxc_cmd_decoder #(
    .NIB_W(NIB_W), .CODE_SOC(CODE_SOC), .CODE_TM(CODE_TM)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .nib_valid(nib_valid), .nib_is_esc(nib_is_esc),
    .nib_data(nib_data), .evt(evt), .tmark_pulse(tmark_pulse), .cmd_err(cmd_err)
  );

  rxc_descrambler #(
    .NIB_W(NIB_W), .GEN_W(GEN_W), .GEN_TAP(GEN_TAP)
  ) dsc_i (
    .clk(clk), .rst_n(rst_n), .nib_valid(nib_valid), .nib_is_esc(nib_is_esc),
    .nib_data(nib_data), .nib_plain(nib_plain)
  );

  rxc_cell_framer #(
    .NIB_W(NIB_W), .CELL_BYTES(CELL_BYTES)
  ) frm_i (
    .clk(clk), .rst_n(rst_n), .evt(evt), .nib_plain(nib_plain),
    .cell_byte(cell_byte), .cell_valid(cell_valid),
    .cell_sop(cell_sop), .cell_eop(cell_eop)
  );
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
  parameter int NIB_W      = 4,
  parameter int CELL_BYTES = 53,
  parameter int CODE_TM    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nib_valid,
  input logic             nib_is_esc,
  input logic [NIB_W-1:0] nib_data,
  input logic             cell_valid,
  input logic             cell_sop,
  input logic             cell_eop,
  input logic             tmark_pulse,
  input logic             cmd_err
);
  localparam int CNT_W = $clog2(CELL_BYTES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_BYTES - 1);

  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_q <= '0;
    else if (cell_valid) seen_q <= cell_sop ? CNT_W'(1) : seen_q + 1'b1;
  end

  AST_SOP_NOT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    cell_sop |-> !cell_eop); // R4
  AST_MARK_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_sop || cell_eop) |-> cell_valid); // R4
  AST_VALID_AFTER_NIB: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> $past(nib_valid && !nib_is_esc)); // R4
  AST_EOP_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    cell_eop |-> (seen_q == LAST)); // R2
  AST_TM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmark_pulse |=> !tmark_pulse); // R1
  AST_TM_FROM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    tmark_pulse |-> $past(nib_valid && !nib_is_esc && nib_data == NIB_W'(CODE_TM))); // R1
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err); // R9
  AST_ERR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(nib_valid && !nib_is_esc)); // R9
endmodule

bind rxc_rx_top rxc_checker #(
  .NIB_W(NIB_W), .CELL_BYTES(CELL_BYTES), .CODE_TM(CODE_TM)
) chk_i (
  .clk(clk), .rst_n(rst_n), .nib_valid(nib_valid), .nib_is_esc(nib_is_esc),
  .nib_data(nib_data), .cell_valid(cell_valid), .cell_sop(cell_sop),
  .cell_eop(cell_eop), .tmark_pulse(tmark_pulse), .cmd_err(cmd_err)
);

// File: tb/rxc_rx_top_tb_top.sv
module rxc_rx_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 7;
  // {esc1, nib1[3:0], esc2, nib2[3:0], exp_tm, exp_err, exp_cell}
  localparam logic [12:0] VEC [NROWS] = '{
    {1'b0, 4'h8, 1'b0, 4'h4, 1'b0, 1'b0, 1'b0},  // stray data, R11
    {1'b1, 4'h0, 1'b0, 4'h4, 1'b0, 1'b0, 1'b1},  // plain start, R2 R5
    {1'b1, 4'h0, 1'b0, 4'h8, 1'b1, 1'b0, 1'b0},  // marker, R1
    {1'b1, 4'h0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1},  // lock start, R2 R6
    {1'b1, 4'h0, 1'b0, 4'h3, 1'b0, 1'b1, 1'b0},  // error, R9
    {1'b1, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0},  // error, R9
    {1'b1, 4'h0, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0}   // error, R9
  };

  logic       clk, rst_n, nib_valid, nib_is_esc;
  logic [3:0] nib_data;
  logic [7:0] cell_byte;
  logic       cell_valid, cell_sop, cell_eop, tmark_pulse, cmd_err;

  int n_chk, n_fail, tm_cnt, err_cnt, rx_cnt, exp_cnt;
  logic [7:0] rx_b [128];
  logic       rx_s [128];
  logic       rx_e [128];
  logic [7:0] ex_b [128];
  logic       ex_s [128];
  logic       ex_e [128];
  logic [9:0] pm;
  logic       prev_m;

  rxc_rx_top dut_i (
    .clk(clk), .rst_n(rst_n), .nib_valid(nib_valid), .nib_is_esc(nib_is_esc),
    .nib_data(nib_data), .cell_byte(cell_byte), .cell_valid(cell_valid),
    .cell_sop(cell_sop), .cell_eop(cell_eop), .tmark_pulse(tmark_pulse),
    .cmd_err(cmd_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (tmark_pulse) tm_cnt++;
      if (cmd_err) err_cnt++;
      if (cell_valid && rx_cnt < 128) begin
        rx_b[rx_cnt] = cell_byte;
        rx_s[rx_cnt] = cell_sop;
        rx_e[rx_cnt] = cell_eop;
        rx_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] step4(input logic [9:0] s);
    logic [9:0] t = s;
    for (int i = 0; i < 4; i++) t = {t[8:0], t[9] ^ t[6]};
    return t;
  endfunction

  task automatic send_nib(input bit esc, input logic [3:0] v);
    @(negedge clk);
    nib_valid  = 1'b1;
    nib_is_esc = esc;
    nib_data   = v;
    if (esc && prev_m) pm = 10'h3FF;
    else               pm = step4(pm);
    prev_m = esc;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    nib_valid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic send_plain(input logic [3:0] p);
    send_nib(1'b0, p ^ pm[9:6]);
  endtask

  task automatic add_exp(input logic [7:0] b, input bit s, input bit e);
    ex_b[exp_cnt] = b; ex_s[exp_cnt] = s; ex_e[exp_cnt] = e; exp_cnt++;
  endtask

  task automatic send_bytes(input int n, input int first, input int seed, input bit last_eop);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(seed + 37 * i);
      send_plain(b[7:4]);
      send_plain(b[3:0]);
      add_exp(b, (first == 0 && i == 0), (last_eop && i == n - 1));
    end
  endtask

  task automatic clear_rx();
    rx_cnt = 0; exp_cnt = 0;
  endtask

  task automatic check_stream(input string req);
    int bad;
    bad = -1;
    check(rx_cnt == exp_cnt, req, rx_cnt, exp_cnt);
    for (int i = 0; i < exp_cnt && i < rx_cnt; i++)
      if (bad < 0 && (rx_b[i] != ex_b[i] || rx_s[i] != ex_s[i] || rx_e[i] != ex_e[i])) bad = i;
    if (bad >= 0)
      check(1'b0, req, {rx_s[bad], rx_e[bad], rx_b[bad]}, {ex_s[bad], ex_e[bad], ex_b[bad]});
    else
      check(1'b1, req, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; nib_valid = 1'b0; nib_is_esc = 1'b0; nib_data = 4'h0;
    pm = 10'h3FF; prev_m = 1'b0;
    repeat (3) @(negedge clk);
    check({cell_valid, cell_sop, cell_eop, tmark_pulse, cmd_err} == 5'b0,
          "R12 in reset", {cell_valid, cell_sop, cell_eop, tmark_pulse, cmd_err}, 0);
    rst_n = 1'b1;
    tm_cnt = 0; err_cnt = 0; clear_rx();
    idle(2);
    check({cell_valid, cell_sop, cell_eop, tmark_pulse, cmd_err} == 5'b0,
          "R12 after reset", {cell_valid, cell_sop, cell_eop, tmark_pulse, cmd_err}, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int tm0, err0;
    n_chk = 0; n_fail = 0;
    do_reset();

    // table walk: command decode R1 R2 R5 R9 R11
    for (int r = 0; r < NROWS; r++) begin
      logic [12:0] v;
      v = VEC[r];
      tm0 = tm_cnt; err0 = err_cnt; clear_rx();
      send_nib(v[12], v[11:8]);
      send_nib(v[7], v[6:3]);
      if (v[0]) send_bytes(53, 0, 16 * r + 5, 1'b1);
      idle(3);
      check(tm_cnt - tm0 == int'(v[2]), "R1 marker count", tm_cnt - tm0, v[2]);
      check(err_cnt - err0 == int'(v[1]), "R9 error count", err_cnt - err0, v[1]);
      check_stream("R2 R3 R4 R5 R11 cell contents");
    end

    // R11: data outside a cell after a complete cell yields nothing
    clear_rx();
    send_nib(1'b1, 4'h0); send_nib(1'b0, 4'h4);
    send_bytes(53, 0, 8'h11, 1'b1);
    send_bytes(3, 1, 8'h90, 1'b0);
    exp_cnt = 53;
    idle(3);
    check_stream("R11 trailing data ignored");

    // R6: first data nibble after escape pair is XORed with 0xF
    clear_rx();
    send_nib(1'b1, 4'h0); send_nib(1'b1, 4'h0);
    send_nib(1'b0, 4'h0);
    send_plain(4'h6);
    add_exp(8'hF6, 1'b1, 1'b0);
    send_bytes(52, 1, 8'h23, 1'b1);
    idle(3);
    check(rx_cnt > 0 && rx_b[0] == 8'hF6, "R6 reload mask", rx_b[0], 8'hF6);
    check_stream("R6 locked cell");

    // R7: escape, escape, escape, 8 then a cell
    clear_rx(); tm0 = tm_cnt;
    send_nib(1'b1, 4'h0); send_nib(1'b1, 4'h0);
    send_nib(1'b1, 4'h0); send_nib(1'b0, 4'h8);
    send_bytes(53, 0, 8'h4C, 1'b1);
    idle(3);
    check(tm_cnt - tm0 == 1, "R7 marker after lock", tm_cnt - tm0, 1);
    check_stream("R7 cell after lock plus marker");

    // R8: marker inside a cell
    clear_rx(); tm0 = tm_cnt;
    send_nib(1'b1, 4'h0); send_nib(1'b1, 4'h0);
    send_bytes(20, 0, 8'h07, 1'b0);
    send_nib(1'b1, 4'h0); send_nib(1'b0, 4'h8);
    send_bytes(33, 20, 8'hA1, 1'b1);
    idle(3);
    check(tm_cnt - tm0 == 1, "R8 marker pulse mid-cell", tm_cnt - tm0, 1);
    check_stream("R8 cell intact around marker");

    // R10: new start aborts partial cell
    clear_rx();
    send_nib(1'b1, 4'h0); send_nib(1'b0, 4'h4);
    send_bytes(10, 0, 8'h33, 1'b0);
    send_plain(4'h9);  // dangling high half
    send_nib(1'b1, 4'h0); send_nib(1'b1, 4'h0);
    send_bytes(53, 0, 8'h5E, 1'b1);
    idle(3);
    check(rx_cnt == 63 && rx_s[10] == 1'b1, "R10 restart sop", rx_cnt, 63);
    check_stream("R10 abort and restart");

    finish_run();
  end
endmodule